// File: doc/BRIEF.md
# Hot-plug I/O expander manager

This block keeps the hot-plug control outputs and status inputs of the downstream ports on external I/O expander chips. Those chips sit on a shared SMBus master. The block holds a shadow copy of every expander's output register. When the port hot-plug logic asks for a new output value, the block sends one transaction that rewrites the whole output register of the expander concerned. When an expander pulls its active-low interrupt line, the block reads that expander's whole input register. It then hands the value back to the port logic with a one-cycle strobe.

Each transaction goes to an SMBus master engine through a simple command and response interface. The block does not start any work until reset and configuration loading are complete. Waiting work is served in a fixed order, so a busy interrupt line cannot hold back a pending output change. A failed transaction is retried a limited number of times. After the last retry fails, the block raises a sticky per-expander error flag and stops serving that expander.

Top module: `hpx_mgr`

## Requirements
- R1: No command is raised while `cfg_done` is low. Requests and interrupts that arrive during that time are held and served once `cfg_done` rises. `cfg_done` stays high once it is set.
- R2: A `set_vld` cycle whose slice for expander i (bits i*OUT_W upward of `set_val`) differs from the shadow leads to one write command with `cmd_rd`=0, `cmd_idx`=i and `cmd_wdata` equal to the full new slice. A slice equal to the shadow causes no transaction.
- R3: Output changes that arrive while a transaction is in flight are merged into the shadow. Exactly one follow-up write is then sent, and it carries the latest value.
- R4: An interrupt line held low, after a two-flop synchronizer, leads to a read command (`cmd_rd`=1) of that expander. If the line is still low when the read completes, another read of the same expander is sent.
- R5: Pending writes are served before pending reads. Within each kind, the lowest expander index goes first.
- R6: While `cmd_vld` is high and `cmd_rdy` is low, `cmd_vld`, `cmd_rd`, `cmd_idx` and `cmd_wdata` hold steady. A transaction ends on the single `rsp_vld` cycle.
- R7: A read that completes without error loads `rsp_rdata` into slice `cmd_idx`*IN_W of `in_vec` on the `rsp_vld` edge. `in_upd` is high for exactly that one cycle, and the other slices do not change.
- R8: A response with `rsp_err` high re-sends the same command. After MAX_RETRY retries also fail, `exp_err[idx]` is set and stays set until reset. After that, the expander receives no further commands, whatever its writes or interrupts.
- R9: During and just after reset, `cmd_vld`, `in_upd`, `in_vec` and `exp_err` are all zero and the shadow is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_done | input | 1 | Reset and configuration loading finished |
| set_vld | input | 1 | Output update request |
| set_val | input | NUM_EXP*OUT_W | Requested output values, one slice per expander |
| exp_int_n | input | NUM_EXP | Asynchronous active-low expander interrupts |
| cmd_vld | output | 1 | Command valid to the SMBus master engine |
| cmd_rd | output | 1 | 1 = read inputs, 0 = write outputs |
| cmd_idx | output | IW | Target expander index |
| cmd_wdata | output | OUT_W | Output register value for writes |
| cmd_rdy | input | 1 | Engine accepts the command |
| rsp_vld | input | 1 | Transaction finished (one cycle) |
| rsp_err | input | 1 | Transaction failed |
| rsp_rdata | input | IN_W | Input register value returned by a read |
| in_vec | output | NUM_EXP*IN_W | Last read-back inputs, one slice per expander |
| in_upd | output | 1 | One-cycle strobe when `in_vec` is updated |
| exp_err | output | NUM_EXP | Sticky per-expander failure flags |

## Verification
The bench holds an output request and two interrupts back behind a low `cfg_done`. When `cfg_done` rises it expects the write first and then the reads in index order. A design that served reads first, or by highest index, would issue the commands in the wrong sequence. It changes an output twice during one write and expects exactly one follow-up write carrying the last value. A design that dropped changes made in flight would send a stale value; one that queued every change would send an extra write. It keeps one interrupt low across a completed read to confirm that a second read follows. It fails a read four times and then confirms that the expander goes quiet with its error flag set. A design that counted retries wrongly, or kept serving the failed expander, would show up either as a missing flag or as further commands.

// File: rtl/hpx_pkg.sv
package hpx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } hpx_state_e;
endpackage

// File: rtl/hpx_sync.sv
// Two-flop synchronizer per line; resets to the inactive (high) level.
module hpx_sync #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] async_in,
   output logic [N-1:0] sync_out
);
   for (genvar g = 0; g < N; g++) begin : g_line
      logic meta_q, sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
         end else begin
            meta_q <= async_in[g];
            sync_q <= meta_q;
         end
      end
      assign sync_out[g] = sync_q;
   end
endmodule

// File: rtl/hpx_shadow.sv
// Shadow of every expander output register with a per-expander dirty bit.
// A new differing value sets dirty; it wins over a same-cycle clear.
module hpx_shadow #(
   parameter int NUM_EXP = 3,
   parameter int OUT_W   = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     set_vld,
   input  logic [NUM_EXP*OUT_W-1:0] set_val,
   input  logic [NUM_EXP-1:0]       clr,
   output logic [NUM_EXP*OUT_W-1:0] shadow,
   output logic [NUM_EXP-1:0]       dirty
);
   for (genvar g = 0; g < NUM_EXP; g++) begin : g_exp
      logic [OUT_W-1:0] val_q;
      logic             dirty_q;
      logic             change;
      assign change = set_vld && (set_val[g*OUT_W +: OUT_W] != val_q);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            val_q   <= '0;
            dirty_q <= 1'b0;
         end else if (change) begin
            val_q   <= set_val[g*OUT_W +: OUT_W];
            dirty_q <= 1'b1;
         end else if (clr[g]) begin
            dirty_q <= 1'b0;
         end
      end
      assign shadow[g*OUT_W +: OUT_W] = val_q;
      assign dirty[g] = dirty_q;
   end
endmodule

// File: rtl/hpx_pick.sv
// Fixed-priority selector: lowest set index wins.
module hpx_pick #(
   parameter int N  = 3,
   parameter int IW = 2
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      any = |req;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/hpx_mgr.sv
module hpx_mgr #(
   parameter int NUM_EXP   = 3,
   parameter int OUT_W     = 8,
   parameter int IN_W      = 8,
   parameter int MAX_RETRY = 3,
   localparam int IW       = (NUM_EXP > 1) ? $clog2(NUM_EXP) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_done,
   input  logic                     set_vld,
   input  logic [NUM_EXP*OUT_W-1:0] set_val,
   input  logic [NUM_EXP-1:0]       exp_int_n,
   output logic                     cmd_vld,
   output logic                     cmd_rd,
   output logic [IW-1:0]            cmd_idx,
   output logic [OUT_W-1:0]         cmd_wdata,
   input  logic                     cmd_rdy,
   input  logic                     rsp_vld,
   input  logic                     rsp_err,
   input  logic [IN_W-1:0]          rsp_rdata,
   output logic [NUM_EXP*IN_W-1:0]  in_vec,
   output logic                     in_upd,
   output logic [NUM_EXP-1:0]       exp_err
);
   import hpx_pkg::*;

   localparam int TW = $clog2(MAX_RETRY + 1) + 1;

   if (NUM_EXP < 1 || NUM_EXP > 16) begin : g_bad_num
      $error("hpx_mgr: NUM_EXP must be 1..16");
   end
   if (OUT_W < 1 || IN_W < 1) begin : g_bad_width
      $error("hpx_mgr: register widths must be positive");
   end
   if (MAX_RETRY < 0 || MAX_RETRY > 15) begin : g_bad_retry
      $error("hpx_mgr: MAX_RETRY must be 0..15");
   end

   hpx_state_e               state_q;
   logic [TW-1:0]            tries_q;
   logic [NUM_EXP-1:0]       int_n_s;
   logic [NUM_EXP*OUT_W-1:0] shadow;
   logic [NUM_EXP-1:0]       dirty;
   logic [NUM_EXP-1:0]       clr;
   logic [NUM_EXP-1:0]       wr_req, rd_req;
   logic                     wr_any, rd_any;
   logic [IW-1:0]            wr_idx, rd_idx;
   logic                     dispatch_wr;

   hpx_sync #(.N(NUM_EXP)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (exp_int_n),
      .sync_out (int_n_s)
   );

   hpx_shadow #(.NUM_EXP(NUM_EXP), .OUT_W(OUT_W)) u_shadow (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vld (set_vld),
      .set_val (set_val),
      .clr     (clr),
      .shadow  (shadow),
      .dirty   (dirty)
   );

   assign wr_req = dirty & ~exp_err;
   assign rd_req = ~int_n_s & ~exp_err;

   hpx_pick #(.N(NUM_EXP), .IW(IW)) u_pick_wr (
      .req (wr_req), .any (wr_any), .idx (wr_idx)
   );
   hpx_pick #(.N(NUM_EXP), .IW(IW)) u_pick_rd (
      .req (rd_req), .any (rd_any), .idx (rd_idx)
   );

   assign dispatch_wr = (state_q == ST_IDLE) && cfg_done && wr_any;

   always_comb begin
      clr = '0;
      if (dispatch_wr) clr[wr_idx] = 1'b1;
   end

   assign cmd_vld = (state_q == ST_ISSUE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         tries_q   <= '0;
         cmd_rd    <= 1'b0;
         cmd_idx   <= '0;
         cmd_wdata <= '0;
         in_vec    <= '0;
         in_upd    <= 1'b0;
         exp_err   <= '0;
      end else begin
         in_upd <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (dispatch_wr) begin
                  cmd_rd    <= 1'b0;
                  cmd_idx   <= wr_idx;
                  cmd_wdata <= shadow[wr_idx*OUT_W +: OUT_W];
                  tries_q   <= '0;
                  state_q   <= ST_ISSUE;
               end else if (cfg_done && rd_any) begin
                  cmd_rd  <= 1'b1;
                  cmd_idx <= rd_idx;
                  tries_q <= '0;
                  state_q <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               if (cmd_rdy) state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (rsp_vld) begin
                  if (rsp_err) begin
                     if (tries_q == TW'(MAX_RETRY)) begin
                        exp_err[cmd_idx] <= 1'b1;
                        state_q          <= ST_IDLE;
                     end else begin
                        tries_q <= tries_q + 1'b1;
                        state_q <= ST_ISSUE;
                     end
                  end else begin
                     if (cmd_rd) begin
                        in_vec[cmd_idx*IN_W +: IN_W] <= rsp_rdata;
                        in_upd                       <= 1'b1;
                     end
                     state_q <= ST_IDLE;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/hpx_mgr_chk.sv
module hpx_mgr_chk #(
   parameter int NUM_EXP = 3,
   parameter int OUT_W   = 8,
   parameter int IN_W    = 8,
   parameter int IW      = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    cfg_done,
   input logic                    cmd_vld,
   input logic                    cmd_rd,
   input logic [IW-1:0]           cmd_idx,
   input logic [OUT_W-1:0]        cmd_wdata,
   input logic                    cmd_rdy,
   input logic                    rsp_vld,
   input logic                    rsp_err,
   input logic                    in_upd,
   input logic [NUM_EXP-1:0]      exp_err
);
   assert_cfg_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_vld) |-> $past(cfg_done));

   assert_cmd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld && !cmd_rdy) |=> (cmd_vld && $stable(cmd_rd) && $stable(cmd_idx)
                                 && $stable(cmd_wdata)));

   assert_upd_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_upd |=> !in_upd);

   assert_upd_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_upd |-> $past(rsp_vld && !rsp_err && cmd_rd));

   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((exp_err & $past(exp_err)) == $past(exp_err)));

   assert_err_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_vld) |-> !exp_err[cmd_idx]);
endmodule

bind hpx_mgr hpx_mgr_chk #(
   .NUM_EXP (NUM_EXP),
   .OUT_W   (OUT_W),
   .IN_W    (IN_W),
   .IW      (IW)
) u_chk (.*);

// File: tb/hpx_mgr_bench.sv
module hpx_mgr_bench;
   localparam int NE = 3;
   localparam int OW = 8;
   localparam int INW = 8;
   localparam int IW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_done = 1'b0;
   logic set_vld = 1'b0;
   logic [NE*OW-1:0] set_val = '0;
   logic [NE-1:0] exp_int_n = '1;
   logic cmd_vld, cmd_rd;
   logic [IW-1:0] cmd_idx;
   logic [OW-1:0] cmd_wdata;
   logic cmd_rdy = 1'b1;
   logic rsp_vld = 1'b0;
   logic rsp_err = 1'b0;
   logic [INW-1:0] rsp_rdata = '0;
   logic [NE*INW-1:0] in_vec;
   logic in_upd;
   logic [NE-1:0] exp_err;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [OW-1:0] model [NE];

   always #2.5 clk = ~clk;

   hpx_mgr #(.NUM_EXP(NE), .OUT_W(OW), .IN_W(INW), .MAX_RETRY(3)) u_hpx_mgr (
      .clk, .rst_n, .cfg_done, .set_vld, .set_val, .exp_int_n,
      .cmd_vld, .cmd_rd, .cmd_idx, .cmd_wdata, .cmd_rdy,
      .rsp_vld, .rsp_err, .rsp_rdata, .in_vec, .in_upd, .exp_err
   );

   // write vectors: {expander index, new value}
   localparam logic [IW+OW-1:0] WR_VEC [5] = '{
      {2'd0, 8'h3C}, {2'd2, 8'hFF}, {2'd1, 8'h00}, {2'd0, 8'h81}, {2'd1, 8'hC3}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic set_out(input int idx, input logic [OW-1:0] val);
      model[idx] = val;
      for (int i = 0; i < NE; i++) set_val[i*OW +: OW] = model[i];
      set_vld = 1'b1;
      @(negedge clk);
      set_vld = 1'b0;
   endtask

   task automatic quiet(input int n, input string req);
      bit seen = 1'b0;
      for (int i = 0; i < n; i++) begin
         if (cmd_vld) seen = 1'b1;
         @(negedge clk);
      end
      chk(req, 32'(seen), 32'd0);
   endtask

   task automatic serve(input string req, input bit rd, input int idx,
                        input logic [OW-1:0] wd, input bit err,
                        input logic [INW-1:0] rdata, input int rel);
      int w = 0;
      while (!cmd_vld && w < 60) begin
         @(negedge clk);
         w++;
      end
      chk({req, " command seen"}, 32'(cmd_vld), 32'd1);
      chk({req, " kind"}, 32'(cmd_rd), 32'(rd));
      chk({req, " index"}, 32'(cmd_idx), 32'(idx));
      if (!rd) chk({req, " write data"}, 32'(cmd_wdata), 32'(wd));
      if (rel >= 0) exp_int_n[rel] = 1'b1;
      repeat (4) @(negedge clk);
      rsp_vld = 1'b1;
      rsp_err = err;
      rsp_rdata = rdata;
      @(negedge clk);
      rsp_vld = 1'b0;
      rsp_err = 1'b0;
      if (rd && !err) begin
         chk({req, " in_upd strobe R7"}, 32'(in_upd), 32'd1);
         chk({req, " in_vec slice R7"}, 32'(in_vec[idx*INW +: INW]), 32'(rdata));
         @(negedge clk);
         chk({req, " in_upd one cycle R7"}, 32'(in_upd), 32'd0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NE; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 cmd_vld", 32'(cmd_vld), 32'd0);
      chk("R9 in_vec", 32'(in_vec), 32'd0);
      chk("R9 exp_err", 32'(exp_err), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 in_upd", 32'(in_upd), 32'd0);

      // R1: work held while configuration loads
      set_out(1, 8'hA5);
      exp_int_n[0] = 1'b0;
      exp_int_n[2] = 1'b0;
      quiet(20, "R1 no command before cfg_done");
      cfg_done = 1'b1;
      // R5: write first, then reads in ascending index
      serve("R5 first write", 1'b0, 1, 8'hA5, 1'b0, '0, -1);
      serve("R5 read exp0", 1'b1, 0, '0, 1'b0, 8'h11, 0);
      serve("R5 read exp2", 1'b1, 2, '0, 1'b0, 8'h22, 2);
      chk("R7 other slices kept", 32'(in_vec), 32'h220011);
      quiet(10, "R4 idle with lines high");

      // R2 vector table
      foreach (WR_VEC[k]) begin
         set_out(int'(WR_VEC[k][IW+OW-1:OW]), WR_VEC[k][OW-1:0]);
         serve("R2 table write", 1'b0, int'(WR_VEC[k][IW+OW-1:OW]),
               WR_VEC[k][OW-1:0], 1'b0, '0, -1);
      end
      set_out(2, 8'hFF);
      quiet(15, "R2 unchanged value sends nothing");

      // R3 merge during flight
      set_out(0, 8'h55);
      fork
         serve("R3 first write", 1'b0, 0, 8'h55, 1'b0, '0, -1);
         begin
            repeat (2) @(negedge clk);
            set_out(0, 8'h66);
            set_out(0, 8'h77);
         end
      join
      serve("R3 merged follow-up", 1'b0, 0, 8'h77, 1'b0, '0, -1);
      quiet(15, "R3 single follow-up");

      // R4 level-sensitive reread
      exp_int_n[1] = 1'b0;
      serve("R4 read", 1'b1, 1, '0, 1'b0, 8'h01, -1);
      serve("R4 reread", 1'b1, 1, '0, 1'b0, 8'h02, 1);
      quiet(10, "R4 stop after release");

      // R8 retries then sticky error
      exp_int_n[0] = 1'b0;
      for (int t = 0; t < 4; t++)
         serve("R8 failing read", 1'b1, 0, '0, 1'b1, '0, -1);
      chk("R8 error flag", 32'(exp_err), 32'd1);
      chk("R8 no strobe on failure", 32'(in_upd), 32'd0);
      set_out(0, 8'h99);
      quiet(30, "R8 failed expander ignored");
      chk("R8 error sticky", 32'(exp_err), 32'd1);
      set_out(2, 8'h42);
      serve("R8 healthy expander served", 1'b0, 2, 8'h42, 1'b0, '0, -1);

      // R6 handshake hold
      cmd_rdy = 1'b0;
      set_out(1, 8'h3C);
      @(negedge clk);
      for (int i = 0; i < 5; i++) begin
         chk("R6 held valid", 32'(cmd_vld), 32'd1);
         chk("R6 held data", 32'({cmd_rd, cmd_idx, cmd_wdata}), 32'({1'b0, 2'd1, 8'h3C}));
         @(negedge clk);
      end
      cmd_rdy = 1'b1;
      serve("R6 released write", 1'b0, 1, 8'h3C, 1'b0, '0, -1);
      quiet(10, "R6 nothing after");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule